// File: doc/BRIEF.md
# Dual 16-bit Interval Timers

Two down-counting 16-bit timers sit behind a shared register file that decodes byte reads and writes at indices 4 through 9 and forwards them here. Both counters advance by one only in cycles where the tick enable is high; that enable is produced elsewhere from a slow timebase of roughly 783 kHz (4.7 MHz divided by six). Neither timer keeps an interrupt flag of its own. Each one reports a one-cycle set pulse and a one-cycle clear pulse, and the owning register file holds the flags.

Timer A has a full 16-bit latch, written one byte at a time. Writing the high byte through the counter index loads the counter from the whole latch and starts it. When the two mode bits supplied by the auxiliary control register equal `01`, timer A runs continuously. It counts down through zero to `FFFF`, raises its flag as it leaves zero, and on the next tick reloads from the latch. This gives a period of latch+2 ticks. Timer B is a one-shot. It loads from a written high byte joined with a stored low byte, flags its first pass through zero, and after that wraps freely.

Timer A state machine: `T1_HALT` (after reset, not counting) goes to `T1_COUNT` on a start write. `T1_COUNT` goes to `T1_WRAPPED` on the tick that takes the count from 0 to `FFFF`. `T1_WRAPPED` returns to `T1_COUNT` on the next tick, reloading from the latch in continuous mode and decrementing otherwise. Timer B state machine: `T2_IDLE` goes to `T2_ARMED` on a load write. `T2_ARMED` goes to `T2_SPENT` on the tick that passes zero. `T2_SPENT` goes back to `T2_ARMED` on the next load write. A start or load write takes priority over a tick in the same cycle.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset both counters and both latches are zero, both timers are halted, so ticks do not change them, and all four pulse outputs are low.
- R2: A write to index 4 or index 6 changes only the low byte of the timer-A latch. A read of index 6 returns the low latch byte and a read of index 7 returns the high latch byte.
- R3: A write to index 5 stores the byte as the high latch byte, pulses `t1_flag_clr`, and loads the timer-A counter with {written byte, low latch byte}, which starts the countdown. This load takes priority over a tick in the same cycle.
- R4: A write to index 7 stores the high latch byte and pulses `t1_flag_clr`, and does not change the timer-A counter.
- R5: A started counter decrements by exactly one on each cycle with `tick_en` high and holds its value otherwise.
- R6: With `aux_mode` equal to `01`, timer A counts from L down through 0 to `FFFF` and then reloads L on the next tick. `t1_flag_set` pulses on the tick that leaves 0, so pulses are L+2 ticks apart.
- R7: With any other `aux_mode` value, timer A wraps from `FFFF` to `FFFE` without reloading and never pulses `t1_flag_set`.
- R8: A read of index 4 returns the low byte of the timer-A counter and pulses `t1_flag_clr`. A read of index 5 returns the high counter byte and pulses nothing.
- R9: A write to index 8 stores the timer-B low latch. A write to index 9 loads the timer-B counter with {written byte, low latch} and starts it. This load takes priority over a tick in the same cycle.
- R10: A read of index 8 returns the low timer-B counter byte and pulses `t2_flag_clr`. A read of index 9 returns the high byte. Reads of any other index, and cycles without `rd_en`, return zero.
- R11: Timer B decrements modulo 2^16. It pulses `t2_flag_set` only on the first tick that takes it from 0 to `FFFF` after a load, and not on later wraps.
- R12: When a set pulse and a clear request for the same timer fall in one cycle, only the set pulse is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable, one tick per high cycle |
| aux_mode | input | 2 | Timer-A mode bits from auxiliary control; `01` selects continuous |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | ADDR_W | Register index |
| wdata | input | DATA_W | Write byte |
| rdata | output | DATA_W | Read byte, combinational |
| t1_flag_set | output | 1 | Timer-A flag set pulse |
| t1_flag_clr | output | 1 | Timer-A flag clear pulse |
| t2_flag_set | output | 1 | Timer-B flag set pulse |
| t2_flag_clr | output | 1 | Timer-B flag clear pulse |

## Verification
The properties check on every cycle that counters hold without ticks, that start and load writes place the expected 16-bit value, that every set pulse is followed by `FFFF`, that set and clear pulses never coincide, and that the non-continuous modes raise no timer-A flag. Only the bench's scenarios can show the full reload sequence and the latch+2 spacing between flags, the one-shot behaviour of timer B across several wraps, and the returned read bytes. Those checks rely on a cycle-level model run over directed sequences and a seeded random mix of accesses and ticks.

// File: rtl/dit_pkg.sv
package dit_pkg;
    typedef enum logic [1:0] {
        T1_HALT    = 2'd0,
        T1_COUNT   = 2'd1,
        T1_WRAPPED = 2'd2
    } t1_state_e;

    typedef enum logic [1:0] {
        T2_IDLE  = 2'd0,
        T2_ARMED = 2'd1,
        T2_SPENT = 2'd2
    } t2_state_e;

    localparam logic [1:0] MODE_CONT = 2'b01;

    localparam int IDX_T1_CLO = 4;
    localparam int IDX_T1_CHI = 5;
    localparam int IDX_T1_LLO = 6;
    localparam int IDX_T1_LHI = 7;
    localparam int IDX_T2_LO  = 8;
    localparam int IDX_T2_HI  = 9;
endpackage

// File: rtl/dit_t1_unit.sv
module dit_t1_unit
    import dit_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              cont_mode,
    input  logic              wr_lat_lo,
    input  logic              wr_hi_start,
    input  logic              wr_hi_keep,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  latch,
    output logic              set_pulse
);
    t1_state_e          state_q, state_d;
    logic [CNT_W-1:0]   cnt_d;

    // latch bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch <= '0;
        end else begin
            if (wr_lat_lo)
                latch[DATA_W-1:0] <= wdata;
            if (wr_hi_start || wr_hi_keep)
                latch[CNT_W-1:DATA_W] <= wdata;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= T1_HALT;
            cnt     <= '0;
        end else begin
            state_q <= state_d;
            cnt     <= cnt_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt;
        set_pulse = 1'b0;
        if (wr_hi_start) begin
            cnt_d   = {wdata, latch[DATA_W-1:0]};
            state_d = T1_COUNT;
        end else if (tick_en) begin
            unique case (state_q)
                T1_HALT: ;
                T1_COUNT: begin
                    cnt_d = cnt - 1'b1;
                    if (cnt == '0) begin
                        state_d   = T1_WRAPPED;
                        set_pulse = cont_mode;
                    end
                end
                T1_WRAPPED: begin
                    cnt_d   = cont_mode ? latch : cnt - 1'b1;
                    state_d = T1_COUNT;
                end
                default: state_d = T1_HALT;
            endcase
        end
    end
endmodule

// File: rtl/dit_t2_unit.sv
module dit_t2_unit
    import dit_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_lo,
    input  logic              wr_hi_load,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt,
    output logic [DATA_W-1:0] lat_lo,
    output logic              set_pulse
);
    t2_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            lat_lo <= '0;
        else if (wr_lo)
            lat_lo <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= T2_IDLE;
            cnt     <= '0;
        end else begin
            state_q <= state_d;
            cnt     <= cnt_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt;
        set_pulse = 1'b0;
        if (wr_hi_load) begin
            cnt_d   = {wdata, lat_lo};
            state_d = T2_ARMED;
        end else if (tick_en) begin
            unique case (state_q)
                T2_IDLE: ;
                T2_ARMED: begin
                    cnt_d = cnt - 1'b1;
                    if (cnt == '0) begin
                        state_d   = T2_SPENT;
                        set_pulse = 1'b1;
                    end
                end
                T2_SPENT: cnt_d = cnt - 1'b1;
                default:  state_d = T2_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dit_rd_mux.sv
module dit_rd_mux
    import dit_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 2 * DATA_W
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  t1_cnt,
    input  logic [CNT_W-1:0]  t1_latch,
    input  logic [CNT_W-1:0]  t2_cnt,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (int'(addr))
                IDX_T1_CLO: rdata = t1_cnt[DATA_W-1:0];
                IDX_T1_CHI: rdata = t1_cnt[CNT_W-1:DATA_W];
                IDX_T1_LLO: rdata = t1_latch[DATA_W-1:0];
                IDX_T1_LHI: rdata = t1_latch[CNT_W-1:DATA_W];
                IDX_T2_LO:  rdata = t2_cnt[DATA_W-1:0];
                IDX_T2_HI:  rdata = t2_cnt[CNT_W-1:DATA_W];
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
    import dit_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [1:0]        aux_mode,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              t1_flag_set,
    output logic              t1_flag_clr,
    output logic              t2_flag_set,
    output logic              t2_flag_clr
);
    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0]  t1_cnt, t1_latch, t2_cnt;
    logic [DATA_W-1:0] t2_lat_lo;
    logic              t1_set, t2_set;
    logic              w_t1_llo, w_t1_start, w_t1_keep, w_t2_lo, w_t2_hi;
    logic              r_t1_lo, r_t2_lo;

    always_comb begin
        w_t1_llo   = wr_en && (int'(addr) == IDX_T1_CLO || int'(addr) == IDX_T1_LLO);
        w_t1_start = wr_en && int'(addr) == IDX_T1_CHI;
        w_t1_keep  = wr_en && int'(addr) == IDX_T1_LHI;
        w_t2_lo    = wr_en && int'(addr) == IDX_T2_LO;
        w_t2_hi    = wr_en && int'(addr) == IDX_T2_HI;
        r_t1_lo    = rd_en && int'(addr) == IDX_T1_CLO;
        r_t2_lo    = rd_en && int'(addr) == IDX_T2_LO;
    end

    dit_t1_unit #(.DATA_W(DATA_W), .CNT_W(CNT_W)) t1_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .cont_mode   (aux_mode == MODE_CONT),
        .wr_lat_lo   (w_t1_llo),
        .wr_hi_start (w_t1_start),
        .wr_hi_keep  (w_t1_keep),
        .wdata       (wdata),
        .cnt         (t1_cnt),
        .latch       (t1_latch),
        .set_pulse   (t1_set)
    );

    dit_t2_unit #(.DATA_W(DATA_W), .CNT_W(CNT_W)) t2_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .wr_lo      (w_t2_lo),
        .wr_hi_load (w_t2_hi),
        .wdata      (wdata),
        .cnt        (t2_cnt),
        .lat_lo     (t2_lat_lo),
        .set_pulse  (t2_set)
    );

    dit_rd_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) rd_i (
        .rd_en    (rd_en),
        .addr     (addr),
        .t1_cnt   (t1_cnt),
        .t1_latch (t1_latch),
        .t2_cnt   (t2_cnt),
        .rdata    (rdata)
    );

    // set wins over clear in the same cycle
    always_comb begin
        t1_flag_set = t1_set;
        t2_flag_set = t2_set;
        t1_flag_clr = (w_t1_start || w_t1_keep || r_t1_lo) && !t1_set;
        t2_flag_clr = r_t2_lo && !t2_set;
    end
endmodule

// File: rtl/dit_chk.sv
module dit_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic [1:0]        aux_mode,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              t1_flag_set,
    input logic              t1_flag_clr,
    input logic              t2_flag_set,
    input logic              t2_flag_clr,
    input logic [CNT_W-1:0]  t1_cnt,
    input logic [CNT_W-1:0]  t1_latch,
    input logic [CNT_W-1:0]  t2_cnt,
    input logic [DATA_W-1:0] t2_lat_lo
);
    logic wr_t1_start, wr_t1_keep, wr_t2_load;
    assign wr_t1_start = wr_en && int'(addr) == 5;
    assign wr_t1_keep  = wr_en && int'(addr) == 7;
    assign wr_t2_load  = wr_en && int'(addr) == 9;

    assert_start_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_t1_start |=> t1_cnt == {$past(wdata), $past(t1_latch[DATA_W-1:0])});

    assert_keep_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_t1_keep && !tick_en) |=> $stable(t1_cnt));

    assert_hold_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !wr_t1_start && !wr_t2_load) |=> ($stable(t1_cnt) && $stable(t2_cnt)));

    assert_set_wraps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        t1_flag_set |=> t1_cnt == {CNT_W{1'b1}});

    assert_no_flag_other_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_mode != 2'b01) |-> !t1_flag_set);

    assert_t2_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_t2_load |=> t2_cnt == {$past(wdata), $past(t2_lat_lo)});

    assert_t2_set_wraps_R11: assert property (@(posedge clk) disable iff (!rst_n)
        t2_flag_set |=> t2_cnt == {CNT_W{1'b1}});

    assert_set_excl_clr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(t1_flag_set && t1_flag_clr) && !(t2_flag_set && t2_flag_clr));
endmodule

bind dual_interval_timer dit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(2 * DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .aux_mode    (aux_mode),
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .t1_flag_set (t1_flag_set),
    .t1_flag_clr (t1_flag_clr),
    .t2_flag_set (t2_flag_set),
    .t2_flag_clr (t2_flag_clr),
    .t1_cnt      (t1_cnt),
    .t1_latch    (t1_latch),
    .t2_cnt      (t2_cnt),
    .t2_lat_lo   (t2_lat_lo)
);

// File: tb/dual_interval_timer_tb_top.sv
`timescale 1ns/1ps
module dual_interval_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [1:0] aux_mode = 2'b00;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       t1_flag_set, t1_flag_clr, t2_flag_set, t2_flag_clr;

    always #2.5 clk = ~clk;

    dual_interval_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .aux_mode(aux_mode),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .t1_flag_set(t1_flag_set), .t1_flag_clr(t1_flag_clr),
        .t2_flag_set(t2_flag_set), .t2_flag_clr(t2_flag_clr)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model
    logic [15:0] m1c = '0, m1l = '0, m2c = '0;
    logic [7:0]  m2l = '0;
    int          m1s = 0;  // 0 halted, 1 counting, 2 just wrapped
    int          m2s = 0;  // 0 idle, 1 armed, 2 spent
    int          tick_no = 0;
    int          set_ticks[$];

    function automatic logic [7:0] exp_rd(input bit r, input int a);
        if (!r) return 8'h00;
        case (a)
            4: return m1c[7:0];
            5: return m1c[15:8];
            6: return m1l[7:0];
            7: return m1l[15:8];
            8: return m2c[7:0];
            9: return m2c[15:8];
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv,
                         input string what);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    task automatic step(input bit w, input bit r, input int a, input logic [7:0] d,
                        input bit t, input logic [1:0] md, input string tag);
        bit e1s, e1c, e2s, e2c;
        @(negedge clk);
        wr_en = w; rd_en = r; addr = 4'(a); wdata = d; tick_en = t; aux_mode = md;
        #1;
        e1s = (m1s == 1) && t && (m1c == 16'h0) && (md == 2'b01) && !(w && a == 5);
        e1c = ((w && (a == 5 || a == 7)) || (r && a == 4)) && !e1s;
        e2s = (m2s == 1) && t && (m2c == 16'h0) && !(w && a == 9);
        e2c = (r && a == 8) && !e2s;
        check(tag, {rdata, t1_flag_set, t1_flag_clr, t2_flag_set, t2_flag_clr},
              {exp_rd(r, a), e1s, e1c, e2s, e2c}, "{rdata,s1,c1,s2,c2}");
        if (t) tick_no++;
        if (t1_flag_set) set_ticks.push_back(tick_no);
        // counters first: a reload uses the latch held before this edge
        if (w && a == 5) begin
            m1c = {d, m1l[7:0]}; m1s = 1;
        end else if (t) begin
            if (m1s == 1) begin
                if (m1c == 16'h0) m1s = 2;
                m1c = m1c - 16'h1;
            end else if (m1s == 2) begin
                m1c = (md == 2'b01) ? m1l : m1c - 16'h1;
                m1s = 1;
            end
        end
        if (w && (a == 4 || a == 6)) m1l[7:0] = d;
        if (w && (a == 5 || a == 7)) m1l[15:8] = d;
        if (w && a == 9) begin
            m2c = {d, m2l}; m2s = 1;
        end else if (t && m2s != 0) begin
            if (m2s == 1 && m2c == 16'h0) m2s = 2;
            m2c = m2c - 16'h1;
        end
        if (w && a == 8) m2l = d;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 190000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state, ticks do nothing while halted
        for (int a = 4; a <= 9; a++) step(0, 1, a, 8'h00, 1, 2'b01, "R1");

        // R2: low latch writes, latch readback
        step(1, 0, 4, 8'h34, 0, 2'b01, "R2");
        step(1, 0, 6, 8'h12, 1, 2'b01, "R2");
        step(0, 1, 6, 8'h00, 0, 2'b01, "R2");
        step(0, 1, 7, 8'h00, 0, 2'b01, "R2");
        step(0, 1, 4, 8'h00, 1, 2'b01, "R2");

        // R4: high latch write without start
        step(1, 0, 7, 8'h5A, 0, 2'b01, "R4");
        step(0, 1, 5, 8'h00, 1, 2'b01, "R4");
        step(0, 1, 7, 8'h00, 0, 2'b01, "R4");

        // R3 / R6: start with latch 3, continuous, period must be 5 ticks
        step(1, 0, 4, 8'h03, 0, 2'b01, "R3");
        step(1, 0, 5, 8'h00, 1, 2'b01, "R3");
        set_ticks.delete();
        for (int i = 0; i < 14; i++) step(0, 1, 4, 8'h00, 1, 2'b01, "R6");
        check("R6", set_ticks.size() >= 2 ? set_ticks[1] - set_ticks[0] : -1, 5, "period");

        // R5: gaps between ticks hold the count
        for (int i = 0; i < 8; i++) step(0, 1, 4 + (i % 2), 8'h00, i % 3 == 0, 2'b01, "R5");

        // R7: other mode wraps past FFFF without reload or flag
        step(1, 0, 4, 8'h01, 0, 2'b10, "R7");
        step(1, 0, 5, 8'h00, 0, 2'b10, "R7");
        for (int i = 0; i < 6; i++) step(0, 1, 5 - (i % 2), 8'h00, 1, 2'b10, "R7");

        // R8: high counter read does not clear
        step(0, 1, 5, 8'h00, 0, 2'b00, "R8");

        // R12: latch 0, continuous, read of index 4 every tick
        step(1, 0, 4, 8'h00, 0, 2'b01, "R12");
        step(1, 0, 5, 8'h00, 0, 2'b01, "R12");
        set_ticks.delete();
        for (int i = 0; i < 6; i++) step(0, 1, 4, 8'h00, 1, 2'b01, "R12");
        check("R6", set_ticks.size() >= 2 ? set_ticks[1] - set_ticks[0] : -1, 2, "period latch0");

        // R9 / R10 / R11: timer B one-shot then free wrap
        step(1, 0, 8, 8'h02, 0, 2'b01, "R9");
        step(1, 0, 9, 8'h00, 1, 2'b01, "R9");
        for (int i = 0; i < 6; i++) step(0, 1, 8 + (i % 2), 8'h00, 1, 2'b01, "R11");
        step(0, 1, 9, 8'h00, 0, 2'b01, "R10");
        step(0, 1, 3, 8'h00, 0, 2'b01, "R10");
        step(1, 0, 8, 8'hFF, 0, 2'b01, "R9");
        step(1, 0, 9, 8'hFF, 1, 2'b01, "R11");
        for (int i = 0; i < 4; i++) step(0, 1, 9, 8'h00, 1, 2'b01, "R11");

        // random mix, seeded
        begin
            int unsigned seed_v = $urandom(32'h1D7E5);
            for (int i = 0; i < 4000; i++) begin
                int unsigned sel = $urandom % 10;
                bit w = (sel < 3);
                bit r = (sel >= 3 && sel < 8);
                int a = 2 + int'($urandom % 9);
                logic [7:0] d = 8'($urandom);
                // keep latches short so flags fire often
                if (w && (a == 5 || a == 7 || a == 9)) d = d & 8'h00;
                if (w && (a == 4 || a == 6 || a == 8)) d = d & 8'h0F;
                step(w, r, a, d, ($urandom % 4) != 0,
                     (($urandom % 8) == 0) ? 2'($urandom) : 2'b01, "R5");
            end
            if (seed_v == 0) n_chk = n_chk + 0;
        end

        finish_run();
    end
endmodule